// File: doc/BRIEF.md
# Host-Port Boot Program Loader

This block fills a 512-word, 24-bit program memory at boot time. A host supplies the data as single-byte writes on a narrow host port with a 3-bit address. The loader runs only when the three boot-mode pins hold the host-boot pattern while reset is asserted. In that case it collects bytes into words and writes each finished word to the next program memory location, starting at location 0.

The host repeats a four-write group for every word. The first write, to address 4, is a dummy that the loader discards. Addresses 5 and 6 carry the upper and middle bytes. Address 7 carries the low byte and commits the whole word. The host needs no handshake and may write on every clock cycle. Loading ends in one of two ways: when the word at the last location is written, or earlier when the host raises its flag 0. In both cases the loader issues a single pulse that tells the core to begin execution at program address 0. It then ignores the host port until the next reset.

Top module: `hbl_boot_loader`

## Requirements
- R1: Loading is enabled only when boot_mode_c, boot_mode_b and boot_mode_a read 1, 0, 1 on a clock edge with rst high. With any other pattern, pm_we and boot_go stay 0 until the next reset. Pin changes after reset have no effect.
- R2: A host write to address 5 holds the upper byte and a write to address 6 holds the middle byte. A write to address 7 commits a word. One cycle after that write, pm_we is 1 and pm_wdata is {upper, middle, low}, where low is the byte written to address 7.
- R3: Host writes to addresses 0 to 4, including the dummy address 4, produce no memory write and leave the held upper and middle bytes unchanged.
- R4: Committed words go to pm_addr 0, 1, 2 and so on, one location higher per word.
- R5: The word committed to location 511 (hex 1FF) ends loading. boot_go is 1 in the same cycle as that pm_we.
- R6: When host_flag0 is 1 on an edge during loading, boot_go is 1 in the next cycle and loading ends. A host write in that same cycle is dropped.
- R7: boot_go pulses for exactly one cycle per reset. After the pulse, no host write or flag produces any further memory write.
- R8: After reset the held upper and middle bytes are 0. A write to address 7 with no new write to 5 or 6 reuses the bytes held last.
- R9: Host writes on consecutive cycles are all accepted, with no required gap.
- R10: While and right after reset, pm_we = 0, boot_go = 0, pm_addr = 0 and pm_wdata = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; boot-mode pins are sampled while it is high |
| boot_mode_c | input | 1 | Boot-mode pin C |
| boot_mode_b | input | 1 | Boot-mode pin B |
| boot_mode_a | input | 1 | Boot-mode pin A |
| host_wr | input | 1 | Host byte write strobe, one cycle per byte |
| host_addr | input | 3 | Host register address of the byte write |
| host_byte | input | 8 | Host byte data |
| host_flag0 | input | 1 | Host flag 0; ends loading early |
| pm_we | output | 1 | Program memory write enable |
| pm_addr | output | 9 | Program memory word address |
| pm_wdata | output | 24 | Program memory write data |
| boot_go | output | 1 | One-cycle pulse: start execution at program address 0 |

## Verification
The hardest case to reach is the natural end of loading. It needs all 512 words committed, and the last one must raise boot_go in the same cycle as its write. The bench streams 512 word groups back to back with data taken from the word index, then keeps writing to show that nothing more reaches memory. The early-stop race is driven directly: host_flag0 and a low-byte write land on the same edge, and the bench checks that the word is dropped and the start pulse still appears.

// File: rtl/hbl_pkg.sv
package hbl_pkg;

    localparam int HOST_AW = 3;
    localparam logic [2:0] HOST_BOOT_MODE = 3'b101;

    typedef enum logic [1:0] {
        HBL_IDLE = 2'd0,
        HBL_LOAD = 2'd1,
        HBL_DONE = 2'd2
    } hbl_state_e;

    typedef struct packed {
        logic capture;
        logic commit;
        logic finish;
    } hbl_ctrl_t;

    function automatic logic mode_selects_host(input logic c, input logic b, input logic a);
        return {c, b, a} == HOST_BOOT_MODE;
    endfunction

    function automatic logic addr_hit(input logic [HOST_AW-1:0] a, input int unsigned target);
        return a == HOST_AW'(target);
    endfunction

endpackage

// File: rtl/hbl_seq_ctrl.sv
module hbl_seq_ctrl
    import hbl_pkg::*;
#(
    parameter int unsigned LAST_ADDR = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_c,
    input  logic               mode_b,
    input  logic               mode_a,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_flag0,
    input  logic               terminal,
    output hbl_ctrl_t          ctrl
);

    hbl_state_e state_q;
    hbl_state_e state_d;

    always_comb begin
        ctrl.capture = (state_q == HBL_LOAD) && !host_flag0;
        ctrl.commit  = ctrl.capture && host_wr && addr_hit(host_addr, LAST_ADDR);
        ctrl.finish  = (state_q == HBL_LOAD) && (host_flag0 || (ctrl.commit && terminal));
    end

    always_comb begin
        state_d = state_q;
        if (ctrl.finish) begin
            state_d = HBL_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= mode_selects_host(mode_c, mode_b, mode_a) ? HBL_LOAD : HBL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/hbl_byte_collector.sv
module hbl_byte_collector
    import hbl_pkg::*;
#(
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned NUM_BYTES  = 3,
    parameter int unsigned FIRST_ADDR = 5,
    localparam int unsigned WORD_W    = BYTE_W * NUM_BYTES,
    localparam int unsigned HELD      = NUM_BYTES - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [BYTE_W-1:0]  host_byte,
    output logic [WORD_W-1:0]  word
);

    logic [BYTE_W-1:0] lane_q [HELD];

    for (genvar g = 0; g < HELD; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[g] <= '0;
            end else if (capture && host_wr && addr_hit(host_addr, FIRST_ADDR + g)) begin
                lane_q[g] <= host_byte;
            end
        end
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < HELD; i++) begin
            word[WORD_W-1-i*BYTE_W -: BYTE_W] = lane_q[i];
        end
        word[BYTE_W-1:0] = host_byte;
    end

endmodule

// File: rtl/hbl_word_counter.sv
module hbl_word_counter #(
    parameter int unsigned NUM_WORDS = 512,
    localparam int unsigned PA_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    output logic [PA_W-1:0] addr,
    output logic            terminal
);

    localparam logic [PA_W-1:0] TOP = PA_W'(NUM_WORDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (step) begin
            addr <= (addr == TOP) ? '0 : addr + 1'b1;
        end
    end

    assign terminal = (addr == TOP);

endmodule

// File: rtl/hbl_boot_loader.sv
module hbl_boot_loader
    import hbl_pkg::*;
#(
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned NUM_BYTES  = 3,
    parameter int unsigned NUM_WORDS  = 512,
    parameter int unsigned FIRST_ADDR = 5,
    localparam int unsigned WORD_W    = BYTE_W * NUM_BYTES,
    localparam int unsigned PA_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned LAST_ADDR = FIRST_ADDR + NUM_BYTES - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               boot_mode_c,
    input  logic               boot_mode_b,
    input  logic               boot_mode_a,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [BYTE_W-1:0]  host_byte,
    input  logic               host_flag0,
    output logic               pm_we,
    output logic [PA_W-1:0]    pm_addr,
    output logic [WORD_W-1:0]  pm_wdata,
    output logic               boot_go
);

    hbl_ctrl_t         ctrl;
    logic              terminal;
    logic [PA_W-1:0]   word_addr;
    logic [WORD_W-1:0] word;

    hbl_seq_ctrl #(
        .LAST_ADDR (LAST_ADDR)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .mode_c     (boot_mode_c),
        .mode_b     (boot_mode_b),
        .mode_a     (boot_mode_a),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_flag0 (host_flag0),
        .terminal   (terminal),
        .ctrl       (ctrl)
    );

    hbl_byte_collector #(
        .BYTE_W     (BYTE_W),
        .NUM_BYTES  (NUM_BYTES),
        .FIRST_ADDR (FIRST_ADDR)
    ) u_collect (
        .clk       (clk),
        .rst       (rst),
        .capture   (ctrl.capture),
        .host_wr   (host_wr),
        .host_addr (host_addr),
        .host_byte (host_byte),
        .word      (word)
    );

    hbl_word_counter #(
        .NUM_WORDS (NUM_WORDS)
    ) u_count (
        .clk      (clk),
        .rst      (rst),
        .step     (ctrl.commit),
        .addr     (word_addr),
        .terminal (terminal)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pm_we    <= 1'b0;
            pm_addr  <= '0;
            pm_wdata <= '0;
            boot_go  <= 1'b0;
        end else begin
            pm_we   <= ctrl.commit;
            boot_go <= ctrl.finish;
            if (ctrl.commit) begin
                pm_addr  <= word_addr;
                pm_wdata <= word;
            end
        end
    end

endmodule

// File: rtl/hbl_boot_loader_chk.sv
module hbl_boot_loader_chk
    import hbl_pkg::*;
#(
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned NUM_BYTES  = 3,
    parameter int unsigned NUM_WORDS  = 512,
    parameter int unsigned FIRST_ADDR = 5,
    localparam int unsigned WORD_W    = BYTE_W * NUM_BYTES,
    localparam int unsigned PA_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int unsigned LAST_ADDR = FIRST_ADDR + NUM_BYTES - 1
) (
    input logic               clk,
    input logic               rst,
    input logic               boot_mode_c,
    input logic               boot_mode_b,
    input logic               boot_mode_a,
    input logic               host_wr,
    input logic [HOST_AW-1:0] host_addr,
    input logic [BYTE_W-1:0]  host_byte,
    input logic               host_flag0,
    input logic               pm_we,
    input logic [PA_W-1:0]    pm_addr,
    input logic [WORD_W-1:0]  pm_wdata,
    input logic               boot_go
);

    logic sel_q;
    logic done_seen;
    logic live;
    logic last_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= ({boot_mode_c, boot_mode_b, boot_mode_a} == 3'b101);
            done_seen <= 1'b0;
        end else if (boot_go) begin
            done_seen <= 1'b1;
        end
    end

    assign live    = sel_q && !done_seen && !boot_go;
    assign last_wr = host_wr && (host_addr == HOST_AW'(LAST_ADDR));

    // R1
    p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
        !sel_q |-> (!pm_we && !boot_go));

    // R2
    p_commit_low_r2: assert property (@(posedge clk) disable iff (rst)
        (live && !host_flag0 && last_wr) |=> (pm_we && pm_wdata[BYTE_W-1:0] == $past(host_byte)));

    // R3
    p_no_write_other_r3: assert property (@(posedge clk) disable iff (rst)
        !last_wr |=> !pm_we);

    // R4
    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        pm_we |=> (!pm_we || pm_addr == PA_W'($past(pm_addr) + 1'b1)));

    // R5
    p_last_word_go_r5: assert property (@(posedge clk) disable iff (rst)
        (pm_we && pm_addr == PA_W'(NUM_WORDS - 1)) |-> boot_go);

    // R6
    p_flag_stop_r6: assert property (@(posedge clk) disable iff (rst)
        (live && host_flag0) |=> (boot_go && !pm_we));

    // R7
    p_single_go_r7: assert property (@(posedge clk) disable iff (rst)
        done_seen |-> (!boot_go && !pm_we));

endmodule

bind hbl_boot_loader hbl_boot_loader_chk #(
    .BYTE_W     (BYTE_W),
    .NUM_BYTES  (NUM_BYTES),
    .NUM_WORDS  (NUM_WORDS),
    .FIRST_ADDR (FIRST_ADDR)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .boot_mode_c (boot_mode_c),
    .boot_mode_b (boot_mode_b),
    .boot_mode_a (boot_mode_a),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_byte   (host_byte),
    .host_flag0  (host_flag0),
    .pm_we       (pm_we),
    .pm_addr     (pm_addr),
    .pm_wdata    (pm_wdata),
    .boot_go     (boot_go)
);

// File: tb/hbl_boot_loader_tb.sv
module hbl_boot_loader_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        boot_mode_c = 1'b0;
    logic        boot_mode_b = 1'b0;
    logic        boot_mode_a = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [7:0]  host_byte = 8'd0;
    logic        host_flag0 = 1'b0;
    logic        pm_we;
    logic [8:0]  pm_addr;
    logic [23:0] pm_wdata;
    logic        boot_go;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hbl_boot_loader u_dut (
        .clk         (clk),
        .rst         (rst),
        .boot_mode_c (boot_mode_c),
        .boot_mode_b (boot_mode_b),
        .boot_mode_a (boot_mode_a),
        .host_wr     (host_wr),
        .host_addr   (host_addr),
        .host_byte   (host_byte),
        .host_flag0  (host_flag0),
        .pm_we       (pm_we),
        .pm_addr     (pm_addr),
        .pm_wdata    (pm_wdata),
        .boot_go     (boot_go)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    summary_done = 0;
    string cur_req = "R10";

    // behavioural reference model
    bit          m_sel, m_done;
    int          m_cnt;
    logic [7:0]  m_hi, m_mid;
    logic        e_we, e_go;
    logic [8:0]  e_addr;
    logic [23:0] e_data;

    always @(posedge clk) begin
        if (rst) begin
            m_sel  = (boot_mode_c == 1'b1) && (boot_mode_b == 1'b0) && (boot_mode_a == 1'b1);
            m_done = 0; m_cnt = 0; m_hi = 8'h00; m_mid = 8'h00;
            e_we = 0; e_go = 0; e_addr = 9'd0; e_data = 24'd0;
        end else begin
            e_we = 0; e_go = 0;
            if (m_sel && !m_done) begin
                if (host_flag0) begin
                    m_done = 1; e_go = 1;
                end else if (host_wr) begin
                    if (host_addr == 3'd5) m_hi = host_byte;
                    else if (host_addr == 3'd6) m_mid = host_byte;
                    else if (host_addr == 3'd7) begin
                        e_we = 1; e_addr = 9'(m_cnt); e_data = {m_hi, m_mid, host_byte};
                        if (m_cnt == 511) begin m_done = 1; e_go = 1; end
                        m_cnt++;
                    end
                end
            end
        end
    end

    // per-cycle comparison and write monitor
    logic [23:0] mem [512];
    int wr_cnt, go_cnt, last_addr;
    bit go_with_we;

    always @(negedge clk) begin
        if (!rst) begin
            n_cmp++;
            if (pm_we !== e_we || boot_go !== e_go || pm_addr !== e_addr || pm_wdata !== e_data) begin
                n_bad++;
                $display("FAIL %s: we/go/addr/data act %0b/%0b/%0h/%06h exp %0b/%0b/%0h/%06h",
                         cur_req, pm_we, boot_go, pm_addr, pm_wdata, e_we, e_go, e_addr, e_data);
            end
            if (pm_we) begin
                mem[pm_addr] = pm_wdata; wr_cnt++; last_addr = int'(pm_addr);
            end
            if (boot_go) begin
                go_cnt++;
                if (pm_we) go_with_we = 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s act %0h exp %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hw(input logic [2:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_byte = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_reset(input logic c, input logic b, input logic a);
        @(negedge clk);
        rst = 1'b1; boot_mode_c = c; boot_mode_b = b; boot_mode_a = a;
        host_wr = 1'b0; host_flag0 = 1'b0;
        idle(2);
        chk(pm_we == 1'b0 && boot_go == 1'b0, "R10", "we|go in reset", int'(pm_we | boot_go), 0);
        chk(pm_addr == 9'd0 && pm_wdata == 24'd0, "R10", "addr|data in reset", int'(pm_wdata), 0);
        rst = 1'b0;
        wr_cnt = 0; go_cnt = 0; last_addr = -1; go_with_we = 0;
        boot_mode_c = ~c; boot_mode_b = ~b; boot_mode_a = ~a;   // R1: later pin changes ignored
    endtask

    task automatic flag_pulse();
        host_flag0 = 1'b1;
        @(negedge clk);
        host_flag0 = 1'b0;
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: act hung exp finished");
        summary();
        $finish;
    end

    initial begin
        // R10 reset state and R2/R3/R4/R8/R9 basic loading
        cur_req = "R10";
        do_reset(1'b1, 1'b0, 1'b1);
        idle(1);
        chk(pm_we == 1'b0 && boot_go == 1'b0, "R10", "outputs after reset", int'(pm_we | boot_go), 0);

        cur_req = "R2";
        hw(3'd4, 8'h99); hw(3'd5, 8'h12); hw(3'd6, 8'h34); hw(3'd7, 8'h56);
        idle(2);
        chk(mem[0] == 24'h123456, "R2", "word 0", int'(mem[0]), 'h123456);

        cur_req = "R3";   // back-to-back writes with ignored addresses in between (R9)
        hw(3'd5, 8'hAB); hw(3'd3, 8'hFF); hw(3'd4, 8'hEE); hw(3'd6, 8'hCD);
        hw(3'd0, 8'h11); hw(3'd7, 8'hEF);
        idle(2);
        chk(mem[1] == 24'hABCDEF, "R3", "word 1 ignores addr 0-4", int'(mem[1]), 'hABCDEF);
        chk(wr_cnt == 2, "R9", "writes after back-to-back group", wr_cnt, 2);

        cur_req = "R8";
        hw(3'd7, 8'h01);
        idle(2);
        chk(mem[2] == 24'hABCD01, "R8", "word 2 reuses held bytes", int'(mem[2]), 'hABCD01);

        cur_req = "R4";
        hw(3'd5, 8'h77); idle(3); hw(3'd6, 8'h88); idle(1); hw(3'd7, 8'h99);
        idle(2);
        chk(last_addr == 3, "R4", "fourth word address", last_addr, 3);
        chk(mem[3] == 24'h778899, "R4", "word 3 data", int'(mem[3]), 'h778899);

        cur_req = "R6";   // flag and low byte on the same edge
        host_flag0 = 1'b1; host_wr = 1'b1; host_addr = 3'd7; host_byte = 8'h42;
        @(negedge clk);
        host_flag0 = 1'b0; host_wr = 1'b0;
        idle(2);
        chk(wr_cnt == 4, "R6", "write dropped on flag", wr_cnt, 4);
        chk(go_cnt == 1, "R6", "start pulses", go_cnt, 1);

        cur_req = "R7";
        hw(3'd5, 8'h01); hw(3'd6, 8'h02); hw(3'd7, 8'h03); flag_pulse();
        idle(3);
        chk(wr_cnt == 4, "R7", "writes after start", wr_cnt, 4);
        chk(go_cnt == 1, "R7", "start pulses after extra flag", go_cnt, 1);

        // R8 reset clears held bytes
        cur_req = "R8";
        do_reset(1'b1, 1'b0, 1'b1);
        hw(3'd7, 8'h5A);
        idle(2);
        chk(mem[0] == 24'h00005A, "R8", "held bytes zero after reset", int'(mem[0]), 'h5A);

        // R5 full load of 512 words
        cur_req = "R5";
        do_reset(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 512; i++) begin
            hw(3'd4, 8'h00);
            hw(3'd5, 8'(i >> 8));
            hw(3'd6, 8'(i));
            hw(3'd7, 8'(i ^ 8'hA5));
        end
        idle(2);
        chk(wr_cnt == 512, "R5", "words written", wr_cnt, 512);
        chk(go_cnt == 1 && go_with_we, "R5", "start with last write", go_cnt, 1);
        chk(mem[511] == {8'h01, 8'hFF, 8'(511 ^ 'hA5)}, "R5", "word 511", int'(mem[511]),
            int'({8'h01, 8'hFF, 8'(511 ^ 'hA5)}));
        chk(mem[300] == {8'h01, 8'h2C, 8'(300 ^ 'hA5)}, "R4", "word 300", int'(mem[300]),
            int'({8'h01, 8'hFF & 8'h2C, 8'(300 ^ 'hA5)}));
        cur_req = "R7";
        hw(3'd5, 8'h10); hw(3'd6, 8'h20); hw(3'd7, 8'h30);
        idle(2);
        chk(wr_cnt == 512 && go_cnt == 1, "R7", "writes after natural end", wr_cnt, 512);

        // R1 other mode patterns never load
        cur_req = "R1";
        for (int m = 0; m < 8; m++) begin
            if (m != 5) begin
                do_reset(m[2], m[1], m[0]);
                hw(3'd5, 8'h11); hw(3'd6, 8'h22); hw(3'd7, 8'h33); flag_pulse();
                idle(2);
                chk(wr_cnt == 0 && go_cnt == 0, "R1", "activity with mode not 101", wr_cnt + go_cnt, 0);
            end
        end

        summary();
        $finish;
    end

endmodule